// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filter

This block receives asynchronous serial frames that carry nine data bits, for use on multidrop links. The ninth bit sorts each frame into one of two kinds. When it is 1 the frame is an address, and when it is 0 the frame is data. The receive line first passes through a flop synchronizer. The block then samples the line on a tick that runs at a fixed multiple of the baud rate. It assembles each frame in a shift register and hands the result to a single-entry receive buffer.

The host controls an address-filter enable. While the enable is set, the block discards data frames without any trace: the buffer, the ready flag and the overrun flag do not change. Address frames still reach the buffer, so the host software can compare the address with its own node identity. The hardware never clears the enable. The host clears it after it sees its own address, and from then on every frame is delivered. Each buffered frame carries a framing-error bit. If a frame is accepted while the buffer is still unread, the overrun flag is set and the older frame is kept.

Top module: `addr_uart_rx`

## Requirements
- R1: A frame is a low start bit, then nine data bits with the least significant bit first, then a high stop bit. The first data bit lands in `buf_data_o[0]` and the ninth lands in `buf_data_o[8]`.
- R2: While the filter enable is 0, every completed frame is written into the buffer and `ready_o` goes to 1, whatever its ninth bit holds.
- R3: While the filter enable is 1, a frame whose ninth bit is 0 is discarded. `buf_data_o`, `buf_ferr_o`, `ready_o` and `overrun_o` all keep their values.
- R4: While the filter enable is 1, a frame whose ninth bit is 1 is written into the buffer and sets `ready_o`.
- R5: The filter enable (`aden_o`) changes only when the host writes it through `aden_we_i`/`aden_d_i`. Receiving an address frame does not clear it.
- R6: A pulse on `rd_i` clears both `ready_o` and `overrun_o` on the next cycle.
- R7: The line passes through a two-stage synchronizer. With 16 ticks per bit, each bit takes the majority value of tick samples 7, 8 and 9 of that bit. A disturbance that lasts one tick does not change the received value.
- R8: A start bit whose majority sample is high is treated as a false start. The receiver goes back to idle and produces no frame.
- R9: A stop bit whose majority sample is low stores `buf_ferr_o` = 1 together with the accepted frame. A good stop bit stores 0.
- R10: After a stop bit that was sampled low, the receiver waits for the line to go high before it looks for a new start bit. A line held low produces no further frames.
- R11: If a frame is accepted while `ready_o` is 1, `overrun_o` is set and the buffer keeps the older frame. A discarded data frame never sets `overrun_o`.
- R12: The filter decision uses the enable value present in the cycle the stop bit is resolved. A write made during a frame therefore governs that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, asynchronous, idles high |
| tick_i | input | 1 | Oversample strobe, OSR pulses per bit time |
| aden_we_i | input | 1 | Write strobe for the address-filter enable |
| aden_d_i | input | 1 | Value written to the filter enable |
| rd_i | input | 1 | Host read strobe for the buffer |
| buf_data_o | output | 9 | Buffered frame, ninth bit in the MSB |
| buf_ferr_o | output | 1 | Framing error stored with the buffered frame |
| ready_o | output | 1 | Buffer holds unread data (interrupt flag) |
| overrun_o | output | 1 | A frame arrived while the buffer was still full |
| aden_o | output | 1 | Current address-filter enable |

## Verification
If the bit counter or the oversample phase is wrong, the bits in `buf_data_o` come out shifted or rotated. This is visible one stop-bit mid-point after the frame ends, so the swept data patterns expose it on the first frame. A filter that reads a stale enable, or the wrong bit, shows up as `ready_o` rising for a dropped data frame, or failing to rise for an address frame, in the same cycle the stop bit resolves. A broken hold state after a framing error produces a phantom frame about one frame time later, which raises `ready_o` while the line is idle. A wrong overrun policy replaces the older buffered data at once.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int unsigned FRAME_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic               ferr;
    } rx_frame_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic is_address(input rx_frame_t f);
        return f.bits[FRAME_W-1];
    endfunction

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/arx_deframer.sv
module arx_deframer
    import arx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_i,
    input  logic      tick_i,
    output logic      done_o,
    output rx_frame_t frame_o
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] S_A  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] S_B  = CNT_W'(OSR/2);
    localparam logic [CNT_W-1:0] S_C  = CNT_W'(OSR/2 + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(FRAME_W - 1);

    rx_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               va_q, vb_q;
    logic               bitval;

    always_comb bitval = vote3(va_q, vb_q, rx_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            va_q    <= 1'b1;
            vb_q    <= 1'b1;
            done_o  <= 1'b0;
            frame_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                if (state_q == ST_IDLE) begin
                    if (!rx_i) begin
                        state_q <= ST_START;
                        cnt_q   <= CNT_W'(1);
                    end
                end else if (state_q == ST_HOLD) begin
                    if (rx_i) state_q <= ST_IDLE;
                end else begin
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
                    if (cnt_q == S_A) va_q <= rx_i;
                    if (cnt_q == S_B) vb_q <= rx_i;
                    unique case (state_q)
                        ST_START: begin
                            if (cnt_q == S_C && bitval) begin
                                state_q <= ST_IDLE;
                            end else if (cnt_q == LAST) begin
                                state_q <= ST_DATA;
                                idx_q   <= '0;
                            end
                        end
                        ST_DATA: begin
                            if (cnt_q == S_C) shreg_q <= {bitval, shreg_q[FRAME_W-1:1]};
                            if (cnt_q == LAST) begin
                                if (idx_q == TOP) state_q <= ST_STOP;
                                else              idx_q   <= idx_q + 1'b1;
                            end
                        end
                        ST_STOP: begin
                            if (cnt_q == S_C) begin
                                frame_o.bits <= shreg_q;
                                frame_o.ferr <= ~bitval;
                                done_o       <= 1'b1;
                                state_q      <= bitval ? ST_IDLE : ST_HOLD;
                            end
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_false_start_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && tick_i && cnt_q == S_C && bitval) |=> state_q == ST_IDLE);

    assert_hold_no_start_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |=> (state_q == ST_HOLD || state_q == ST_IDLE));

    assert_hold_waits_high_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && !rx_i) |=> state_q == ST_HOLD);

endmodule

// File: rtl/arx_rxbuf.sv
module arx_rxbuf
    import arx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      done_i,
    input  rx_frame_t frame_i,
    input  logic      aden_we_i,
    input  logic      aden_d_i,
    input  logic      rd_i,
    output rx_frame_t buf_o,
    output logic      full_o,
    output logic      ovr_o,
    output logic      aden_o
);
    rx_frame_t buf_q;
    logic      full_q, ovr_q, aden_q;
    logic      accept;

    always_comb accept = done_i & (~aden_q | is_address(frame_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            aden_q <= 1'b0;
            buf_q  <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (aden_we_i) aden_q <= aden_d_i;
            if (accept && (!full_q || rd_i)) begin
                buf_q  <= frame_i;
                full_q <= 1'b1;
            end else if (rd_i) begin
                full_q <= 1'b0;
            end
            if (accept && full_q && !rd_i) ovr_q <= 1'b1;
            else if (rd_i)                 ovr_q <= 1'b0;
        end
    end

    assign buf_o  = buf_q;
    assign full_o = full_q;
    assign ovr_o  = ovr_q;
    assign aden_o = aden_q;

    assert_load_open_R2: assert property (@(posedge clk) disable iff (rst)
        (done_i && !aden_q && !full_q) |=> (full_q && buf_q == $past(frame_i)));

    assert_drop_data_R3: assert property (@(posedge clk) disable iff (rst)
        (done_i && aden_q && !frame_i.bits[FRAME_W-1] && !rd_i)
        |=> ($stable(buf_q) && $stable(full_q) && $stable(ovr_q)));

    assert_load_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (done_i && frame_i.bits[FRAME_W-1] && !full_q) |=> (full_q && buf_q == $past(frame_i)));

    assert_sticky_en_R5: assert property (@(posedge clk) disable iff (rst)
        (aden_q && !aden_we_i) |=> aden_q);

    assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !done_i) |=> (!full_q && !ovr_q));

    assert_overrun_keep_R11: assert property (@(posedge clk) disable iff (rst)
        (accept && full_q && !rd_i) |=> (ovr_q && $stable(buf_q)));

endmodule

// File: rtl/addr_uart_rx.sv
module addr_uart_rx
    import arx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_i,
    input  logic               tick_i,
    input  logic               aden_we_i,
    input  logic               aden_d_i,
    input  logic               rd_i,
    output logic [FRAME_W-1:0] buf_data_o,
    output logic               buf_ferr_o,
    output logic               ready_o,
    output logic               overrun_o,
    output logic               aden_o
);
    logic      rx_s;
    logic      done;
    rx_frame_t frame;
    rx_frame_t held;

    arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (rx_i),
        .q_o (rx_s)
    );

    arx_deframer #(.OSR(OSR)) u_deframe (
        .clk     (clk),
        .rst     (rst),
        .rx_i    (rx_s),
        .tick_i  (tick_i),
        .done_o  (done),
        .frame_o (frame)
    );

    arx_rxbuf u_buf (
        .clk       (clk),
        .rst       (rst),
        .done_i    (done),
        .frame_i   (frame),
        .aden_we_i (aden_we_i),
        .aden_d_i  (aden_d_i),
        .rd_i      (rd_i),
        .buf_o     (held),
        .full_o    (ready_o),
        .ovr_o     (overrun_o),
        .aden_o    (aden_o)
    );

    assign buf_data_o = held.bits;
    assign buf_ferr_o = held.ferr;

endmodule

// File: tb/sim_addr_uart_rx.sv
module sim_addr_uart_rx;

    localparam int BITCLK = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_i = 1'b1;
    logic       tick_i;
    logic       aden_we_i = 1'b0;
    logic       aden_d_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [8:0] buf_data_o;
    logic       buf_ferr_o, ready_o, overrun_o, aden_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) tick_i <= 1'b0;
        else     tick_i <= ~tick_i;
    end

    addr_uart_rx u0 (
        .clk(clk), .rst(rst), .rx_i(rx_i), .tick_i(tick_i),
        .aden_we_i(aden_we_i), .aden_d_i(aden_d_i), .rd_i(rd_i),
        .buf_data_o(buf_data_o), .buf_ferr_o(buf_ferr_o),
        .ready_o(ready_o), .overrun_o(overrun_o), .aden_o(aden_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int n);
        rx_i = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] v, input logic stop, input logic glitch);
        hold_line(1'b0, BITCLK);
        for (int i = 0; i < 9; i++) begin
            if (glitch) begin
                hold_line(v[i], 15);
                hold_line(~v[i], 2);
                hold_line(v[i], 15);
            end else begin
                hold_line(v[i], BITCLK);
            end
        end
        hold_line(stop, BITCLK);
        if (stop) repeat (4) @(negedge clk);
    endtask

    task automatic write_aden(input logic v);
        aden_we_i = 1'b1;
        aden_d_i  = v;
        @(negedge clk);
        aden_we_i = 1'b0;
    endtask

    task automatic do_read();
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] last;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);

        chk("R6", "reset ready", ready_o, 0);
        chk("R11", "reset overrun", overrun_o, 0);
        chk("R5", "reset enable", aden_o, 0);

        // R2 / R1: open mode sweep
        for (int v = 0; v < 512; v += 5) begin
            send_frame(9'(v), 1'b1, 1'b0);
            chk("R2", "open ready", ready_o, 1);
            chk("R1", "open data", buf_data_o, v);
            chk("R9", "good stop ferr", buf_ferr_o, 0);
            do_read();
            chk("R6", "read clears ready", ready_o, 0);
        end
        last = 9'(510);

        // R3 / R4: filtered sweep
        write_aden(1'b1);
        for (int v = 3; v < 512; v += 5) begin
            send_frame(9'(v), 1'b1, 1'b0);
            if (v >= 256) begin
                chk("R4", "address ready", ready_o, 1);
                chk("R4", "address data", buf_data_o, v);
                last = 9'(v);
                do_read();
            end else begin
                chk("R3", "data dropped ready", ready_o, 0);
                chk("R3", "data dropped buffer", buf_data_o, last);
            end
        end
        chk("R5", "enable sticky", aden_o, 1);

        // R11: discarded frames never overrun
        send_frame(9'h101, 1'b1, 1'b0);
        send_frame(9'h022, 1'b1, 1'b0);
        chk("R11", "drop no overrun", overrun_o, 0);
        chk("R3", "drop keeps address", buf_data_o, 9'h101);
        chk("R5", "enable after address", aden_o, 1);
        do_read();

        // host clears enable, data accepted
        write_aden(1'b0);
        send_frame(9'h033, 1'b1, 1'b0);
        chk("R2", "data after clear", buf_data_o, 9'h033);
        do_read();

        // R11: overrun keeps older frame
        send_frame(9'h0A5, 1'b1, 1'b0);
        send_frame(9'h15A, 1'b1, 1'b0);
        chk("R11", "overrun flag", overrun_o, 1);
        chk("R11", "older kept", buf_data_o, 9'h0A5);
        do_read();
        chk("R6", "read clears overrun", overrun_o, 0);
        chk("R6", "read clears ready", ready_o, 0);

        // R12: enable written mid-frame governs that frame
        write_aden(1'b1);
        fork
            send_frame(9'h044, 1'b1, 1'b0);
            begin repeat (160) @(negedge clk); write_aden(1'b0); end
        join
        chk("R12", "cleared mid-frame accepts", ready_o, 1);
        chk("R12", "cleared mid-frame data", buf_data_o, 9'h044);
        do_read();
        fork
            send_frame(9'h055, 1'b1, 1'b0);
            begin repeat (160) @(negedge clk); write_aden(1'b1); end
        join
        chk("R12", "set mid-frame drops", ready_o, 0);
        write_aden(1'b0);

        // R8: false start
        hold_line(1'b0, 8);
        hold_line(1'b1, 64);
        chk("R8", "false start no frame", ready_o, 0);
        send_frame(9'h0C3, 1'b1, 1'b0);
        chk("R8", "frame after false start", buf_data_o, 9'h0C3);
        do_read();

        // R7: one-tick glitch in every bit
        send_frame(9'h1A5, 1'b1, 1'b1);
        chk("R7", "glitch rejected", buf_data_o, 9'h1A5);
        do_read();
        send_frame(9'h05A, 1'b1, 1'b1);
        chk("R7", "glitch rejected 2", buf_data_o, 9'h05A);
        do_read();

        // R9 / R10: framing error, line stays low
        send_frame(9'h17E, 1'b0, 1'b0);
        chk("R9", "ferr ready", ready_o, 1);
        chk("R9", "ferr flag", buf_ferr_o, 1);
        chk("R9", "ferr data", buf_data_o, 9'h17E);
        do_read();
        hold_line(1'b0, 96);
        hold_line(1'b1, 420);
        chk("R10", "no phantom frame", ready_o, 0);
        chk("R10", "no phantom overrun", overrun_o, 0);
        send_frame(9'h0F0, 1'b1, 1'b0);
        chk("R9", "ferr cleared", buf_ferr_o, 0);
        chk("R10", "recovers", buf_data_o, 9'h0F0);
        do_read();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule